// File: doc/BRIEF.md
# SPI Flash Slave Front-End

This block is the serial slave side of a serial flash device. It oversamples chip select, serial clock, serial input and an active-low hold pin with the device clock. It assembles an 8-bit opcode and, for opcodes that carry one, a 24-bit address. It then hands the decoded command to a back-end over a one-cycle strobe. Program data bytes that follow the address are passed on one at a time. For read opcodes, the block asks the back-end for bytes and shifts them out on the serial clock, either one bit per falling edge on the serial-out line or two bits per falling edge using both data lines.

The host may idle the serial clock low or high (SPI modes 0 and 3). Hold pauses the transfer without losing its position. Deselecting always throws away a partial command, so each selection starts with a fresh opcode.

Top module: `spi_flash_front`

## Requirements
- R1: During and after reset with chip select high, both output enables, `cmd_valid`, `wr_valid` and `rd_req` are low.
- R2: Input bits are taken on rising serial-clock edges only, in both SPI mode 0 (clock idle low) and SPI mode 3 (clock idle high).
- R3: Every selection starts with an opcode sent MSB first. Raising chip select before a header completes discards it, and no command is reported.
- R4: Opcodes 03h, 3Bh, 02h, 20h, 52h, D8h and 81h are followed by a 24-bit address sent MSB first. `cmd_valid` pulses for one cycle with `cmd_op` and `cmd_addr` after the last address bit. Any other opcode pulses after its 8th bit with address 0, and later bits in that selection are ignored.
- R5: After the header of opcode 02h, each complete byte (MSB first) gives one `wr_valid` pulse with the byte on `wr_data`. A trailing partial byte gives none.
- R6: After opcode 03h, data bytes stream MSB first on `io1_out` until deselect. The line changes only after falling serial-clock edges, and `io0_oe` stays low.
- R7: After opcode 3Bh, each falling edge presents two bits, the upper on `io1_out` and the lower on `io0_out`, and both enables are high.
- R8: Each read byte is requested by a one-cycle `rd_req` pulse; `rd_data` is taken in the cycle after the pulse. The first request follows the read header.
- R9: While chip select is high, both output enables are low.
- R10: Hold begins when `hold_n` is low while selected and the serial clock is low. While held, clock and input changes are ignored and both enables are low. After `hold_n` returns high, the transfer resumes from the same bit with the same output value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data in (lower line in dual read) |
| hold_n | input | 1 | Hold request, active low |
| io1_out | output | 1 | Serial-out line value (upper bit in dual read) |
| io1_oe | output | 1 | Drive enable for the serial-out line |
| io0_out | output | 1 | Lower data bit during dual read |
| io0_oe | output | 1 | Drive enable for the lower data line |
| cmd_valid | output | 1 | One-cycle strobe: header decoded |
| cmd_op | output | 8 | Decoded opcode |
| cmd_addr | output | ADDR_W | Decoded address (0 for opcodes without one) |
| wr_valid | output | 1 | One-cycle strobe: program byte ready |
| wr_data | output | 8 | Program byte |
| rd_req | output | 1 | One-cycle request for the next read byte |
| rd_data | input | 8 | Read byte from back-end, valid the cycle after `rd_req` |

## Verification
The checker assumes that each serial-clock level and each hold level lasts at least four device-clock cycles, so that every pin change passes through the synchronizer before the next one. It also assumes that hold is released only while the serial clock is low, and that the back-end answers `rd_req` one cycle later. The bench host holds every clock phase for eight device cycles. It starts and ends each hold inside a low clock phase, and its back-end model registers the next byte on the clock after each request. Under those conditions, every strobe must trace back to a qualified serial-clock edge, and no output may move between falling edges.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  localparam int OP_W   = 8;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_OP,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_DONE
  } phase_t;

  localparam logic [OP_W-1:0] OP_READ   = 8'h03;
  localparam logic [OP_W-1:0] OP_DREAD  = 8'h3B;
  localparam logic [OP_W-1:0] OP_PROG   = 8'h02;
  localparam logic [OP_W-1:0] OP_ER_4K  = 8'h20;
  localparam logic [OP_W-1:0] OP_ER_32K = 8'h52;
  localparam logic [OP_W-1:0] OP_ER_64K = 8'hD8;
  localparam logic [OP_W-1:0] OP_ER_PG  = 8'h81;

  function automatic logic takes_addr(input logic [OP_W-1:0] op);
    case (op)
      OP_READ, OP_DREAD, OP_PROG, OP_ER_4K, OP_ER_32K, OP_ER_64K, OP_ER_PG:
        return 1'b1;
      default:
        return 1'b0;
    endcase
  endfunction

  function automatic logic is_read(input logic [OP_W-1:0] op);
    return (op == OP_READ) || (op == OP_DREAD);
  endfunction

  function automatic logic is_dual(input logic [OP_W-1:0] op);
    return op == OP_DREAD;
  endfunction

  function automatic logic is_prog(input logic [OP_W-1:0] op);
    return op == OP_PROG;
  endfunction

  // bits presented per falling edge
  function automatic logic [3:0] lane_step(input logic dual);
    return dual ? 4'd2 : 4'd1;
  endfunction

  function automatic logic [BYTE_W-1:0] shift_out(input logic [BYTE_W-1:0] v,
                                                  input logic dual);
    return dual ? {v[BYTE_W-3:0], 2'b00} : {v[BYTE_W-2:0], 1'b0};
  endfunction

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= RST_VAL;
        else        st[g] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= RST_VAL;
        else        st[g] <= st[g-1];
      end
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx
  import spi_fe_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              rise_ev,
  input  logic              si,
  output logic              cmd_valid,
  output logic [OP_W-1:0]   cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_data
);

  localparam int CNT_W = $clog2(ADDR_W);
  localparam logic [CNT_W-1:0] OP_LAST   = CNT_W'(OP_W - 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTE_W - 1);

  phase_t            phase;
  logic [CNT_W-1:0]  cnt;
  logic [OP_W-1:0]   op_sh;
  logic [ADDR_W-1:0] addr_sh;
  logic [BYTE_W-1:0] byte_sh;

  logic [OP_W-1:0]   op_next;
  logic [ADDR_W-1:0] addr_next;
  logic [BYTE_W-1:0] byte_next;

  assign op_next   = {op_sh[OP_W-2:0], si};
  assign addr_next = {addr_sh[ADDR_W-2:0], si};
  assign byte_next = {byte_sh[BYTE_W-2:0], si};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_OP;
      cnt       <= '0;
      op_sh     <= '0;
      addr_sh   <= '0;
      byte_sh   <= '0;
      cmd_valid <= 1'b0;
      cmd_op    <= '0;
      cmd_addr  <= '0;
      wr_valid  <= 1'b0;
      wr_data   <= '0;
    end else begin
      cmd_valid <= 1'b0;
      wr_valid  <= 1'b0;
      if (!sel) begin
        phase <= PH_OP;
        cnt   <= '0;
      end else if (rise_ev) begin
        unique case (phase)
          PH_OP: begin
            op_sh <= op_next;
            if (cnt == OP_LAST) begin
              cnt <= '0;
              if (takes_addr(op_next)) begin
                phase <= PH_ADDR;
              end else begin
                phase     <= PH_DONE;
                cmd_valid <= 1'b1;
                cmd_op    <= op_next;
                cmd_addr  <= '0;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_ADDR: begin
            addr_sh <= addr_next;
            if (cnt == ADDR_LAST) begin
              cnt       <= '0;
              cmd_valid <= 1'b1;
              cmd_op    <= op_sh;
              cmd_addr  <= addr_next;
              if (is_read(op_sh))      phase <= PH_RDATA;
              else if (is_prog(op_sh)) phase <= PH_WDATA;
              else                     phase <= PH_DONE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_WDATA: begin
            byte_sh <= byte_next;
            if (cnt == BYTE_LAST) begin
              cnt      <= '0;
              wr_valid <= 1'b1;
              wr_data  <= byte_next;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx
  import spi_fe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              on_hold,
  input  logic              fall_ev,
  input  logic              rd_start,
  input  logic              rd_dual,
  output logic              rd_req,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              io1_out,
  output logic              io1_oe,
  output logic              io0_out,
  output logic              io0_oe
);

  localparam logic [3:0] FULL = 4'(BYTE_W);

  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] nxt;
  logic [3:0]        left;
  logic              active;
  logic              started;
  logic              dual_q;
  logic              req_q;
  logic              pend;
  logic              drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      nxt     <= '0;
      left    <= '0;
      active  <= 1'b0;
      started <= 1'b0;
      dual_q  <= 1'b0;
      req_q   <= 1'b0;
      pend    <= 1'b0;
    end else begin
      req_q <= 1'b0;
      pend  <= req_q;
      if (pend) nxt <= rd_data;
      if (!sel) begin
        active  <= 1'b0;
        started <= 1'b0;
        left    <= '0;
        dual_q  <= 1'b0;
      end else if (rd_start) begin
        active <= 1'b1;
        dual_q <= rd_dual;
        req_q  <= 1'b1;
      end else if (fall_ev && active) begin
        if (left == '0) begin
          sh      <= nxt;
          left    <= FULL - lane_step(dual_q);
          req_q   <= 1'b1;
          started <= 1'b1;
        end else begin
          sh   <= shift_out(sh, dual_q);
          left <= left - lane_step(dual_q);
        end
      end
    end
  end

  assign drive   = started && sel && !on_hold;
  assign rd_req  = req_q;
  assign io1_out = sh[BYTE_W-1];
  assign io0_out = sh[BYTE_W-2];
  assign io1_oe  = drive;
  assign io0_oe  = drive && dual_q;

endmodule

// File: rtl/spi_flash_front.sv
module spi_flash_front
  import spi_fe_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  output logic              io1_out,
  output logic              io1_oe,
  output logic              io0_out,
  output logic              io0_oe,
  output logic              cmd_valid,
  output logic [7:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              wr_valid,
  output logic [7:0]        wr_data,
  output logic              rd_req,
  input  logic [7:0]        rd_data
);

  // pin order {cs_n, sck, si, hold_n}; idle: deselected, clock low, no hold
  localparam logic [3:0] PIN_IDLE = 4'b1001;

  logic [3:0] pins_s;
  logic cs_s, sck_s, si_s, hold_s;
  logic sck_prev;
  logic on_hold;
  logic sel;
  logic rise_ev;
  logic fall_ev;
  logic rd_start;
  logic rd_dual;

  spi_fe_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, sck, si, hold_n}),
    .q     (pins_s)
  );

  assign {cs_s, sck_s, si_s, hold_s} = pins_s;
  assign sel = !cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      on_hold  <= 1'b0;
    end else begin
      sck_prev <= sck_s;
      if (!sel)                          on_hold <= 1'b0;
      else if (!on_hold && !hold_s && !sck_s) on_hold <= 1'b1;
      else if (on_hold && hold_s)        on_hold <= 1'b0;
    end
  end

  assign rise_ev  = sel && !on_hold && sck_s && !sck_prev;
  assign fall_ev  = sel && !on_hold && !sck_s && sck_prev;
  assign rd_start = cmd_valid && is_read(cmd_op);
  assign rd_dual  = is_dual(cmd_op);

  spi_fe_rx #(.ADDR_W(ADDR_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .rise_ev   (rise_ev),
    .si        (si_s),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data)
  );

  spi_fe_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .on_hold  (on_hold),
    .fall_ev  (fall_ev),
    .rd_start (rd_start),
    .rd_dual  (rd_dual),
    .rd_req   (rd_req),
    .rd_data  (rd_data),
    .io1_out  (io1_out),
    .io1_oe   (io1_oe),
    .io0_out  (io0_out),
    .io0_oe   (io0_oe)
  );

endmodule

// File: rtl/spi_flash_front_chk.sv
module spi_flash_front_chk (
  input logic clk,
  input logic rst_n,
  input logic sel,
  input logic on_hold,
  input logic sck_s,
  input logic rise_ev,
  input logic fall_ev,
  input logic rd_start,
  input logic cmd_valid,
  input logic wr_valid,
  input logic rd_req,
  input logic io1_out,
  input logic io1_oe,
  input logic io0_oe
);

  assert_cmd_after_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(rise_ev));

  assert_cmd_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  assert_wr_after_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(rise_ev));

  assert_no_cmd_wr_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && wr_valid));

  assert_out_moves_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(io1_oe) && io1_oe && !$past(fall_ev)) |-> $stable(io1_out));

  assert_dual_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    io0_oe |-> io1_oe);

  assert_req_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> $past(rd_start || fall_ev));

  assert_req_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  assert_off_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (!io1_oe && !io0_oe));

  assert_hold_clock_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_hold) |-> !$past(sck_s));

  assert_hold_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (on_hold && $past(on_hold)) |-> (!cmd_valid && !wr_valid && !io1_oe));

endmodule

bind spi_flash_front spi_flash_front_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel       (sel),
  .on_hold   (on_hold),
  .sck_s     (sck_s),
  .rise_ev   (rise_ev),
  .fall_ev   (fall_ev),
  .rd_start  (rd_start),
  .cmd_valid (cmd_valid),
  .wr_valid  (wr_valid),
  .rd_req    (rd_req),
  .io1_out   (io1_out),
  .io1_oe    (io1_oe),
  .io0_oe    (io0_oe)
);

// File: tb/spi_flash_front_bench.sv
`timescale 1ns/1ps
module spi_flash_front_bench;

  localparam int H = 8;  // device cycles per serial clock level

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic si = 1'b0;
  logic hold_n = 1'b1;
  logic [7:0] rd_data = 8'h00;
  logic io1_out, io1_oe, io0_out, io0_oe;
  logic cmd_valid, wr_valid, rd_req;
  logic [7:0] cmd_op, wr_data;
  logic [23:0] cmd_addr;

  int checks = 0;
  int fails = 0;
  int bk_idx = 0;
  logic idle_hi = 1'b0;

  typedef struct packed { logic [7:0] op; logic [23:0] addr; } cmd_t;
  cmd_t cmd_q[$];
  logic [7:0] wr_q[$];

  always #2.5 clk = ~clk;

  spi_flash_front u_spi_flash_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
    .io1_out(io1_out), .io1_oe(io1_oe), .io0_out(io0_out), .io0_oe(io0_oe),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data)
  );

  function automatic logic [7:0] pat(int k);
    return 8'((k * 29) + 8'h5A);
  endfunction

  // back-end model: answers each request one cycle later (R8)
  always @(posedge clk) begin
    if (cs_n) bk_idx <= 0;
    else if (rd_req) begin
      rd_data <= pat(bk_idx);
      bk_idx  <= bk_idx + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    cmd_t e;
    if (rst_n && cmd_valid) begin
      if (cmd_q.size() == 0) chk("R3 unexpected command", {24'h0, cmd_op}, 32'hFFFF_FFFF);
      else begin
        e = cmd_q.pop_front();
        chk("R4 command opcode", {24'h0, cmd_op}, {24'h0, e.op});
        chk("R4 command address", {8'h0, cmd_addr}, {8'h0, e.addr});
      end
    end
    if (rst_n && wr_valid) begin
      if (wr_q.size() == 0) chk("R5 unexpected write byte", {24'h0, wr_data}, 32'hFFFF_FFFF);
      else chk("R5 write byte", {24'h0, wr_data}, {24'h0, wr_q.pop_front()});
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cyc(input logic b, input bit hold_here, output logic r1, output logic r0);
    logic oe_before;
    sck = 1'b0;
    si = b;
    wait_clk(H);
    r1 = io1_out;
    r0 = io0_out;
    oe_before = io1_oe;
    if (hold_here) begin
      hold_n = 1'b0;
      wait_clk(4);
      chk("R10 io1 released on hold", {31'h0, io1_oe}, 32'h0);
      chk("R10 io0 released on hold", {31'h0, io0_oe}, 32'h0);
      repeat (3) begin
        sck = 1'b1; si = ~si; wait_clk(H);
        sck = 1'b0; wait_clk(H);
      end
      si = b;
      hold_n = 1'b1;
      wait_clk(H);
      chk("R10 output value kept over hold", {31'h0, io1_out}, {31'h0, r1});
      chk("R10 drive restored after hold", {31'h0, io1_oe}, {31'h0, oe_before});
    end
    sck = 1'b1;
    wait_clk(H);
  endtask

  task automatic send_byte(input logic [7:0] b, input int hold_bit);
    logic d1, d0;
    for (int i = 7; i >= 0; i--) bit_cyc(b[i], i == hold_bit, d1, d0);
  endtask

  task automatic send_addr(input logic [23:0] a);
    send_byte(a[23:16], -1);
    send_byte(a[15:8], -1);
    send_byte(a[7:0], -1);
  endtask

  task automatic recv_byte(input bit dual, input int hold_step, output logic [7:0] v);
    logic r1, r0;
    v = 8'h00;
    if (dual) begin
      for (int i = 0; i < 4; i++) begin
        bit_cyc(1'b0, i == hold_step, r1, r0);
        v = {v[5:0], r1, r0};
      end
    end else begin
      for (int i = 0; i < 8; i++) begin
        bit_cyc(1'b0, i == hold_step, r1, r0);
        v = {v[6:0], r1};
      end
    end
  endtask

  task automatic begin_xfer(input bit mode3);
    idle_hi = mode3;
    sck = mode3;
    wait_clk(H);
    cs_n = 1'b0;
    wait_clk(H);
  endtask

  task automatic end_xfer();
    sck = idle_hi;
    wait_clk(H);
    cs_n = 1'b1;
    wait_clk(2 * H);
    chk("R9 io1 off when deselected", {31'h0, io1_oe}, 32'h0);
    chk("R9 io0 off when deselected", {31'h0, io0_oe}, 32'h0);
  endtask

  task automatic do_read(input bit mode3, input bit dual, input logic [23:0] a,
                         input int n, input int hold_byte, input int hold_step);
    logic [7:0] v;
    cmd_q.push_back({dual ? 8'h3B : 8'h03, a});
    begin_xfer(mode3);
    send_byte(dual ? 8'h3B : 8'h03, -1);
    send_addr(a);
    for (int j = 0; j < n; j++) begin
      recv_byte(dual, (j == hold_byte) ? hold_step : -1, v);
      if (dual) begin
        chk("R7 dual read byte", {24'h0, v}, {24'h0, pat(j)});
        chk("R7 lower line driven", {31'h0, io0_oe}, 32'h1);
      end else begin
        chk("R6 single read byte", {24'h0, v}, {24'h0, pat(j)});
        chk("R6 lower line idle", {31'h0, io0_oe}, 32'h0);
      end
      chk("R8 upper line driven", {31'h0, io1_oe}, 32'h1);
    end
    end_xfer();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    wait_clk(4);
    chk("R1 io1_oe in reset", {31'h0, io1_oe}, 32'h0);
    chk("R1 cmd_valid in reset", {31'h0, cmd_valid}, 32'h0);
    rst_n = 1'b1;
    wait_clk(6);
    chk("R1 outputs idle after reset",
        {27'h0, io1_oe, io0_oe, cmd_valid, wr_valid, rd_req}, 32'h0);

    // R2 R6 R8: mode 0 single read
    do_read(1'b0, 1'b0, 24'h012345, 3, -1, -1);
    // R2 R7: mode 3 dual read
    do_read(1'b1, 1'b1, 24'h01F0AA, 3, -1, -1);

    // R5: program, three bytes then a partial nibble
    cmd_q.push_back({8'h02, 24'h000100});
    wr_q.push_back(8'h11); wr_q.push_back(8'hA2); wr_q.push_back(8'h3C);
    begin_xfer(1'b0);
    send_byte(8'h02, -1);
    send_addr(24'h000100);
    send_byte(8'h11, -1); send_byte(8'hA2, -1); send_byte(8'h3C, -1);
    begin
      logic d1, d0;
      for (int i = 0; i < 4; i++) bit_cyc(1'b1, 1'b0, d1, d0);
    end
    end_xfer();

    // R4: opcode without address, later bits ignored
    cmd_q.push_back({8'h06, 24'h000000});
    begin_xfer(1'b1);
    send_byte(8'h06, -1);
    send_byte(8'h03, -1);
    send_addr(24'h123456);
    end_xfer();
    chk("R4 no read requested after ignored bits", {31'h0, rd_req}, 32'h0);

    // R3: abort mid-address, then a fresh command
    begin_xfer(1'b0);
    send_byte(8'h20, -1);
    send_byte(8'h01, -1);
    end_xfer();
    cmd_q.push_back({8'h52, 24'h018000});
    begin_xfer(1'b0);
    send_byte(8'h52, -1);
    send_addr(24'h018000);
    end_xfer();

    // R10: hold inside the opcode
    cmd_q.push_back({8'hD8, 24'h00ABCD});
    begin_xfer(1'b1);
    send_byte(8'hD8, 4);
    send_addr(24'h00ABCD);
    end_xfer();

    // R10: hold inside read data, single and dual
    do_read(1'b0, 1'b0, 24'h000777, 3, 1, 3);
    do_read(1'b1, 1'b1, 24'h010203, 2, 0, 1);

    wait_clk(20);
    chk("R4 every expected command seen", cmd_q.size(), 0);
    chk("R5 every expected write byte seen", wr_q.size(), 0);
    summary();
    $finish;
  end

endmodule